// File: doc/BRIEF.md
# Stepper Phase Sequence Generator

This block turns a slow step clock into the drive pattern for a two-phase bipolar stepper motor. It keeps a position on an eight-place ring. Each rising edge of the step clock moves that position one place in half-step mode, or two places in full-step mode. Clockwise steps go up the ring and counterclockwise steps go down. For each of the two bridges, A and B, the position gives a polarity bit and an active bit, which a downstream bridge controller turns into leg switching.

Full-step mode has no pattern setting of its own. A two-place move keeps the parity of the position, so the position held when half-step is turned off sets the pattern. An even position runs two phases on, and an odd position runs one phase on. The step clock, direction, mode and home inputs are external, so each passes through a synchroniser on the fast system clock before the step edge is detected. The drive enable acts straight on the outputs.

Top module: `stepper_phase_seq`

## Requirements
- R1: Each rising edge of `step_clk` moves the position exactly once. The new outputs appear after the third rising edge of `clk` that follows the input edge, and are unchanged after the second. With no rising step edge the position does not move.
- R2: With `cw` high a step raises the position (mod 8). With `cw` low a step lowers it by the same amount.
- R3: With `half_mode` high a step moves the position by 1.
- R4: With `half_mode` low a step moves the position by 2. An even position keeps both bridges active, and an odd position keeps exactly one bridge active.
- R5: While `home_n` is low the position is forced to 0 (home) within three `clk` edges, and step edges are ignored.
- R6: While `drive_en` is low all four outputs are 0 at once, without waiting for a clock edge. The position is kept, and steps still move it.
- R7: The outputs for position k are given by m = (k+1) mod 8. Bridge A is inactive for m in {2,6}, positive for m in {7,0,1} and negative for m in {3,4,5}. Bridge B is inactive for m in {0,4}, positive for m in {1,2,3} and negative for m in {5,6,7}. Positive means pol=1, act=1. Negative means pol=0, act=1. Inactive means pol=0, act=0.
- R8: Changing `cw` or `half_mode` without a step edge leaves the outputs unchanged. The new value is used from the next step on.
- R9: While `rst_n` is low at a `clk` edge the position returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| step_clk | input | 1 | Step clock, asynchronous; a rising edge makes one step |
| cw | input | 1 | Direction: 1 clockwise (up), 0 counterclockwise (down) |
| half_mode | input | 1 | Step size: 1 half-step, 0 full-step |
| home_n | input | 1 | Active-low return to position 0, asynchronous |
| drive_en | input | 1 | Active-high drive enable; low turns every output off |
| a_pol | output | 1 | Bridge A polarity |
| a_act | output | 1 | Bridge A active |
| b_pol | output | 1 | Bridge B polarity |
| b_act | output | 1 | Bridge B active |

## Verification
A step or home input reaches the outputs after three `clk` edges: two synchroniser stages, then the position register. The bench drives every input on a falling edge. It checks the old pattern on the second falling edge after the input change and the new pattern on the third. The enable acts combinationally, so its checks are made one nanosecond after the drive, away from any clock edge. A system reset is checked on the falling edge after the first reset edge.

// File: rtl/stepseq_pkg.sv
// Shared types for the stepper phase sequencer.
// Assumes an eight-place position ring (3 bits).
package stepseq_pkg;
    localparam int POS_W = 3;
    typedef logic [POS_W-1:0] pos_t;

    // Drive request for one bridge.
    typedef struct packed {
        logic pol;
        logic act;
    } bridge_t;
endpackage

// File: rtl/stepseq_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous levels.
// Assumes each bit is a slow level; no bus coherence is promised.
module stepseq_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the sampled levels through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/stepseq_edge.sv
// Rising-edge detector on an already synchronised level.
// Assumes the level stays low while rst_n is asserted.
module stepseq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_d;

    // Keep the previous level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/stepseq_counter.sv
// Position ring counter. It moves by one or two places per step pulse,
// up or down, and returns to home while home_ok is low.
// Assumes step, up and half are synchronous to clk.
module stepseq_counter
    import stepseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic home_ok,
    input  logic step,
    input  logic up,
    input  logic half,
    output pos_t pos
);
    localparam pos_t HALF_DELTA = pos_t'(1);
    localparam pos_t FULL_DELTA = pos_t'(2);
    localparam pos_t HOME_POS   = '0;

    pos_t delta;
    pos_t nxt;

    // Choose the move size and direction for a pending step.
    always_comb begin
        delta = half ? HALF_DELTA : FULL_DELTA;
        nxt   = up ? pos + delta : pos - delta;
    end

    // Position register: reset and home take priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos <= HOME_POS;
        else if (!home_ok) pos <= HOME_POS;
        else if (step)    pos <= nxt;
    end

    // R1: no step pulse, no movement.
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (home_ok && !step) |=> $stable(pos));
    // R5: home forces position zero.
    p_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !home_ok |=> pos == HOME_POS);
    // R3: half step up moves by one.
    p_half_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (home_ok && step && half && up) |=> pos_t'(pos - $past(pos)) == pos_t'(1));
    // R2: half step down moves back by one.
    p_half_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (home_ok && step && half && !up) |=> pos_t'(pos - $past(pos)) == pos_t'(7));
    // R4: full step moves by two in the chosen direction.
    p_full_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (home_ok && step && !half && up) |=> pos_t'(pos - $past(pos)) == pos_t'(2));
    p_full_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (home_ok && step && !half && !up) |=> pos_t'(pos - $past(pos)) == pos_t'(6));
    // R4: full step keeps parity.
    p_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (home_ok && step && !half) |=> pos[0] == $past(pos[0]));
endmodule

// File: rtl/stepseq_decode.sv
// Maps a ring position to the two bridge drive requests.
// The pattern follows the signs of cos and sin at (k+1)*45 degrees.
module stepseq_decode
    import stepseq_pkg::*;
(
    input  pos_t    pos,
    output bridge_t br_a,
    output bridge_t br_b
);
    pos_t ph;

    // Shift to the phase angle index and derive the sign of each winding.
    always_comb begin
        ph = pos + pos_t'(1);
        br_a.act = (ph[1:0] != 2'b10);
        br_a.pol = br_a.act && (ph == 3'd7 || ph == 3'd0 || ph == 3'd1);
        br_b.act = (ph[1:0] != 2'b00);
        br_b.pol = br_b.act && (ph >= 3'd1 && ph <= 3'd3);
    end
endmodule

// File: rtl/stepper_phase_seq.sv
// Stepper phase sequence generator top. It synchronises the external
// controls, detects step edges, keeps the ring position and decodes
// the bridge pattern. Assumes step_clk is held low during rst_n.
module stepper_phase_seq
    import stepseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_clk,
    input  logic cw,
    input  logic half_mode,
    input  logic home_n,
    input  logic drive_en,
    output logic a_pol,
    output logic a_act,
    output logic b_pol,
    output logic b_act
);
    localparam int NCTL = 4;

    logic [NCTL-1:0] ctl_raw;
    logic [NCTL-1:0] ctl_s;
    logic            step_pulse;
    pos_t            pos;
    bridge_t         br_a;
    bridge_t         br_b;

    assign ctl_raw = {home_n, half_mode, cw, step_clk};

    stepseq_sync #(
        .W       (NCTL),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    stepseq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ctl_s[0]),
        .rise  (step_pulse)
    );

    stepseq_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .home_ok (ctl_s[3]),
        .step    (step_pulse),
        .up      (ctl_s[1]),
        .half    (ctl_s[2]),
        .pos     (pos)
    );

    stepseq_decode u_dec (
        .pos  (pos),
        .br_a (br_a),
        .br_b (br_b)
    );

    // Gate every output with the drive enable.
    always_comb begin
        a_pol = br_a.pol & drive_en;
        a_act = br_a.act & drive_en;
        b_pol = br_b.pol & drive_en;
        b_act = br_b.act & drive_en;
    end

    // R6: disabled means all outputs off.
    p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> !(a_pol || a_act || b_pol || b_act));
    // R7: an inactive bridge never requests a polarity.
    p_idle_pol_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !a_act |-> !a_pol);
    p_idle_pol_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !b_act |-> !b_pol);
    // R7: when enabled, at least one bridge is driven.
    p_alive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (a_act || b_act));
endmodule

// File: tb/sim_stepper_phase_seq.sv
module sim_stepper_phase_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_clk = 1'b0;
    logic cw = 1'b1;
    logic half_mode = 1'b1;
    logic home_n = 1'b1;
    logic drive_en = 1'b1;
    logic a_pol, a_act, b_pol, b_act;

    int total = 0;
    int bad = 0;
    int exp_pos = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stepper_phase_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_clk  (step_clk),
        .cw        (cw),
        .half_mode (half_mode),
        .home_n    (home_n),
        .drive_en  (drive_en),
        .a_pol     (a_pol),
        .a_act     (a_act),
        .b_pol     (b_pol),
        .b_act     (b_act)
    );

    wire [3:0] obs = {a_pol, a_act, b_pol, b_act};

    // Expected {a_pol,a_act,b_pol,b_act} from winding signs at (k+1)*45 deg.
    function automatic logic [3:0] pat(input int k);
        int  m;
        logic ap, aa, bp, ba;
        m  = (k + 1) % 8;
        aa = !(m == 2 || m == 6);
        ap = (m == 7 || m == 0 || m == 1);
        ba = !(m == 0 || m == 4);
        bp = (m >= 1 && m <= 3);
        return {ap, aa, bp, ba};
    endfunction

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", req, got, want);
        end
    endtask

    task automatic nwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One step: old pattern at 2nd falling edge, new at 3rd (R1).
    task automatic step_once(input string req);
        int d;
        logic [3:0] old;
        old = pat(exp_pos);
        d = half_mode ? 1 : 2;
        exp_pos = cw ? (exp_pos + d) % 8 : (exp_pos + 8 - d) % 8;
        step_clk = 1'b1;
        nwait(2);
        chk("R1 timing", obs, old);
        nwait(1);
        chk(req, obs, pat(exp_pos));
        step_clk = 1'b0;
        nwait(3);
    endtask

    task automatic set_ctl(input logic dir, input logic hm);
        cw = dir;
        half_mode = hm;
        nwait(3);
    endtask

    initial begin
        nwait(4);
        chk("R9 reset", obs, pat(0));
        rst_n = 1'b1;
        nwait(3);
        chk("R7 home", obs, 4'b1111);

        // R3 R2 R7: half step both ways over two turns.
        set_ctl(1'b1, 1'b1);
        for (int i = 0; i < 16; i++) step_once("R3 half cw");
        set_ctl(1'b0, 1'b1);
        for (int i = 0; i < 16; i++) step_once("R2 half ccw");

        // R4: full step from even position, two phases on.
        set_ctl(1'b1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            step_once("R4 full even");
            chk("R4 two-on", {2'b00, a_act, b_act}, 4'b0011);
        end
        // R4: move to odd position, then full step one phase on.
        set_ctl(1'b1, 1'b1);
        step_once("R3 to odd");
        set_ctl(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step_once("R4 full odd cw");
            chk("R4 one-on", {3'b000, a_act ^ b_act}, 4'b0001);
        end
        set_ctl(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step_once("R4 full odd ccw");

        // R8: control changes without a step do nothing.
        cw = ~cw; half_mode = ~half_mode;
        nwait(6);
        chk("R8 no step", obs, pat(exp_pos));
        cw = ~cw;
        nwait(6);
        chk("R8 no step", obs, pat(exp_pos));

        // R6: enable gating at every position; steps continue while off.
        set_ctl(1'b1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            drive_en = 1'b0;
            #1;
            chk("R6 off", obs, 4'b0000);
            nwait(1);
            step_clk = 1'b1;
            nwait(3);
            chk("R6 off held", obs, 4'b0000);
            step_clk = 1'b0;
            nwait(3);
            exp_pos = (exp_pos + 1) % 8;
            drive_en = 1'b1;
            #1;
            chk("R6 resume", obs, pat(exp_pos));
            nwait(1);
        end

        // R5: home input, with steps ignored while low.
        step_once("R3 pre home");
        home_n = 1'b0;
        nwait(3);
        exp_pos = 0;
        chk("R5 home", obs, pat(0));
        step_clk = 1'b1;
        nwait(4);
        chk("R5 step ignored", obs, pat(0));
        step_clk = 1'b0;
        nwait(3);
        home_n = 1'b1;
        nwait(3);
        step_once("R5 step after home");

        // R9: system reset mid-run.
        step_once("R3 pre reset");
        rst_n = 1'b0;
        nwait(1);
        exp_pos = 0;
        chk("R9 reset mid", obs, pat(0));
        nwait(2);
        rst_n = 1'b1;
        nwait(4);
        chk("R9 after reset", obs, pat(0));
        step_once("R3 after reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule